// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block controls the run, idle and power-down states of a small microcontroller, and it decides when the chip is held in reset. It watches the external reset pin and counts oscillator periods. It asserts the internal reset only after the pin has stayed high for two full machine cycles while the oscillator runs. It takes two request bits from a control register, one for idle and one for power-down. From these it drives three enables: a CPU clock enable, a peripheral clock enable and an oscillator enable. The two clock enables run at half the raw clock rate.

Idle stops only the CPU enable, and the peripherals keep counting. Idle ends on any pending enabled interrupt or on a qualified reset. Power-down switches the oscillator off and freezes both clock enables. The only way out of power-down is the reset pin: raising the pin turns the oscillator back on, and then qualification runs as usual. When a mode ends, the block emits a one-cycle clear strobe to the register that holds the request bits, so execution resumes in the run state.

Top module: `pm_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `mode_o` is 0 (run), `sys_rst_o` and `req_clr_o` are 0, and `osc_en_o` is 1. The mode encoding is run=0, idle=1, power-down=2, reset=3.
- R2: `sys_rst_o` goes to 1 after the 24th consecutive rising edge at which `rst_pin` is high and the oscillator was running before that edge. A high pulse that lasts 23 edges leaves `sys_rst_o` at 0.
- R3: While `sys_rst_o` is 1, `mode_o` is 3. On the first edge with `rst_pin` low, `sys_rst_o` returns to 0 and `mode_o` becomes 0.
- R4: In the run mode, `cpu_ce_o` and `per_ce_o` are each high on exactly every second cycle, so each is high 10 times in any 20 cycles.
- R5: `idle_req` in the run mode makes `mode_o` 1 after the next edge. In idle, `cpu_ce_o` stays 0 and `per_ce_o` keeps its half-rate pattern.
- R6: In idle, `irq_pend` high at an edge returns `mode_o` to 0 after that edge.
- R7: `pd_req` in the run mode makes `mode_o` 2 after the next edge. In power-down, `osc_en_o`, `cpu_ce_o` and `per_ce_o` are 0 while `rst_pin` is low.
- R8: In power-down, `irq_pend`, `idle_req` and `pd_req` have no effect. Raising `rst_pin` sets `osc_en_o` after the first edge, and `sys_rst_o` rises after the 25th edge with the pin high.
- R9: If `idle_req` and `pd_req` are both high in the run mode, the mode becomes power-down.
- R10: `req_clr_o` is high for exactly one cycle after any exit from idle or power-down. In that cycle the run mode ignores the request inputs.
- R11: A qualified reset during idle moves `mode_o` to 3 and pulses `req_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | External reset pin, active high, not yet qualified |
| idle_req | input | 1 | Idle request bit from the control register |
| pd_req | input | 1 | Power-down request bit from the control register |
| irq_pend | input | 1 | An enabled interrupt is pending |
| sys_rst_o | output | 1 | Qualified internal reset |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| req_clr_o | output | 1 | One-cycle strobe that clears the request bits |
| mode_o | output | 2 | Current mode: 0 run, 1 idle, 2 power-down, 3 reset |

## Verification
The hardest case to reach from the ports is a reset that arrives while the oscillator is stopped. This needs two conditions at once. First, power-down must be entered and held while interrupts and requests arrive and have no effect. Second, the pin must be raised so that the oscillator restarts one edge before qualification begins, which is why that path takes 25 edges instead of 24. Directed sequences build this case, and also a request that is still set in the cycle right after an exit. Seeded random stimulus then mixes long and short reset pulses with requests and interrupts, and each cycle is compared against a mode model in the bench.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_RESET = 2'd3
  } pm_mode_e;
endpackage

// File: rtl/pm_phase.sv
// Divides the running oscillator into clock-enable ticks.
// The counter only advances while the oscillator runs, so the phase freezes in power-down.
module pm_phase #(
  parameter int OSC_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSC_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (run)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == '0);

  generate
    if (OSC_DIV > 1) begin : g_gap_chk
      // R4: two ticks never fall on back-to-back cycles
      a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pm_rst_qual.sv
// Counts consecutive oscillator periods with the reset pin high.
// The internal reset asserts only when the count reaches QUAL.
module pm_rst_qual #(
  parameter int QUAL = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic run,
  output logic hit_d,
  output logic hit_q
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!pin)
      cnt_d = '0;
    else if (run && (cnt_q != FULL))
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  assign hit_d = pin && (cnt_d == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  // R2: the internal reset rises only while the pin is held high
  a_r2_rise_pin_high: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_q) |-> $past(pin));
  // R3: the internal reset falls only after the pin has dropped
  a_r3_fall_pin_low: assert property (@(posedge clk) disable iff (rst)
    $fell(hit_q) |-> !$past(pin));
endmodule

// File: rtl/pm_mode_fsm.sv
// Mode sequencer: run, idle, power-down and reset, with asymmetric exits.
module pm_mode_fsm
  import pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rst_hit,
  input  logic     idle_req,
  input  logic     pd_req,
  input  logic     irq_pend,
  output pm_mode_e mode_d,
  output pm_mode_e mode_q,
  output logic     guard_q
);
  logic exit_d;

  always_comb begin
    mode_d = mode_q;
    if (rst_hit)
      mode_d = PM_RESET;
    else begin
      unique case (mode_q)
        PM_RESET: mode_d = PM_RUN;
        PM_RUN: begin
          if (!guard_q) begin
            if (pd_req)
              mode_d = PM_PDOWN;
            else if (idle_req)
              mode_d = PM_IDLE;
          end
        end
        PM_IDLE:  if (irq_pend) mode_d = PM_RUN;
        PM_PDOWN: mode_d = PM_PDOWN;
        default:  mode_d = PM_RUN;
      endcase
    end
  end

  assign exit_d = ((mode_q == PM_IDLE) || (mode_q == PM_PDOWN)) && (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PM_RUN;
      guard_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      guard_q <= exit_d;
    end
  end

  // R8: power-down is left only towards the reset state
  a_r8_pd_only_reset: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_PDOWN) |=> (mode_q == PM_PDOWN) || (mode_q == PM_RESET));
  // R9: power-down wins over idle when both requests are set
  a_r9_pd_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_RUN && !guard_q && pd_req && idle_req && !rst_hit) |=> (mode_q == PM_PDOWN));
  // R6: a pending interrupt ends idle
  a_r6_irq_wakes: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_IDLE && irq_pend && !rst_hit) |=> (mode_q == PM_RUN));
endmodule

// File: rtl/pm_ctrl.sv
// Top: qualifies reset, sequences the low-power modes and registers every output.
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int OSC_DIV   = 2,
  parameter int MC_STATES = 6,
  parameter int RST_MCYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin,
  input  logic       idle_req,
  input  logic       pd_req,
  input  logic       irq_pend,
  output logic       sys_rst_o,
  output logic       cpu_ce_o,
  output logic       per_ce_o,
  output logic       osc_en_o,
  output logic       req_clr_o,
  output logic [1:0] mode_o
);
  localparam int OSC_PER_MC = OSC_DIV * MC_STATES;
  localparam int QUAL       = OSC_PER_MC * RST_MCYC;

  logic     tick, hit_d, hit_q, guard_q;
  pm_mode_e mode_d, mode_q;
  logic     osc_q, cpu_q, per_q;

  pm_phase #(.OSC_DIV(OSC_DIV)) u_phase (
    .clk (clk), .rst (rst), .run (osc_q), .tick (tick)
  );

  pm_rst_qual #(.QUAL(QUAL)) u_qual (
    .clk (clk), .rst (rst), .pin (rst_pin), .run (osc_q),
    .hit_d (hit_d), .hit_q (hit_q)
  );

  pm_mode_fsm u_fsm (
    .clk (clk), .rst (rst), .rst_hit (hit_d),
    .idle_req (idle_req), .pd_req (pd_req), .irq_pend (irq_pend),
    .mode_d (mode_d), .mode_q (mode_q), .guard_q (guard_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q <= 1'b1;
      cpu_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      osc_q <= (mode_d != PM_PDOWN) || rst_pin;
      cpu_q <= tick && (mode_d == PM_RUN);
      per_q <= tick && ((mode_d == PM_RUN) || (mode_d == PM_IDLE));
    end
  end

  assign sys_rst_o = hit_q;
  assign cpu_ce_o  = cpu_q;
  assign per_ce_o  = per_q;
  assign osc_en_o  = osc_q;
  assign req_clr_o = guard_q;
  assign mode_o    = mode_q;

  // R7: no clock enable while powered down
  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> !cpu_ce_o && !per_ce_o);
  // R5: the CPU enable stays off in idle
  a_r5_idle_cpu_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> !cpu_ce_o);
  // R10: the clear strobe lasts one cycle
  a_r10_clr_single: assert property (@(posedge clk) disable iff (rst)
    req_clr_o |=> !req_clr_o);
  // R3: the reset mode and the internal reset go together
  a_r3_mode_tracks_rst: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (mode_o == 2'd3));
endmodule

// File: tb/tb_pm_ctrl.sv
module tb_pm_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0;
  logic sys_rst_o, cpu_ce_o, per_ce_o, osc_en_o, req_clr_o;
  logic [1:0] mode_o;

  int errs = 0, checks = 0;
  bit done = 0;
  bit auto_clr = 1;

  // bench reference state
  int m_mode = 0, m_cnt = 0;
  bit m_rst = 0, m_osc = 1, m_clr = 0;
  int n_cpu = 0, n_per = 0;

  pm_ctrl dut (
    .clk (clk), .rst (rst), .rst_pin (rst_pin), .idle_req (idle_req),
    .pd_req (pd_req), .irq_pend (irq_pend), .sys_rst_o (sys_rst_o),
    .cpu_ce_o (cpu_ce_o), .per_ce_o (per_ce_o), .osc_en_o (osc_en_o),
    .req_clr_o (req_clr_o), .mode_o (mode_o)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_mode(int mode, bit hit, bit clr, bit ir, bit pr, bit iq);
    if (hit) return 3;
    case (mode)
      3: return 0;
      0: begin
        if (clr) return 0;
        if (pr) return 2;
        if (ir) return 1;
        return 0;
      end
      1: return iq ? 0 : 1;
      default: return 2;
    endcase
  endfunction

  // one clock: predict, advance, compare
  task automatic step();
    int cnt_n, mode_n;
    bit hit_n, osc_n, clr_n;
    if (!rst_pin) cnt_n = 0;
    else if (m_osc && m_cnt < 24) cnt_n = m_cnt + 1;
    else cnt_n = m_cnt;
    hit_n  = rst_pin && (cnt_n == 24);
    mode_n = next_mode(m_mode, hit_n, m_clr, idle_req, pd_req, irq_pend);
    clr_n  = (m_mode == 1 || m_mode == 2) && (mode_n != m_mode);
    osc_n  = (mode_n != 2) || rst_pin;
    @(posedge clk);
    @(negedge clk);
    m_cnt = cnt_n; m_rst = hit_n; m_mode = mode_n; m_clr = clr_n; m_osc = osc_n;
    check(mode_o == 2'(m_mode), "R6 mode", int'(mode_o), m_mode);
    check(sys_rst_o == m_rst, "R2 sys_rst", int'(sys_rst_o), int'(m_rst));
    check(osc_en_o == m_osc, "R7 osc_en", int'(osc_en_o), int'(m_osc));
    check(req_clr_o == m_clr, "R10 req_clr", int'(req_clr_o), int'(m_clr));
    check(!(cpu_ce_o && m_mode != 0), "R5 cpu_ce outside run", int'(cpu_ce_o), 0);
    check(!(per_ce_o && m_mode >= 2), "R7 per_ce gated", int'(per_ce_o), 0);
    n_cpu += int'(cpu_ce_o);
    n_per += int'(per_ce_o);
    if (auto_clr && (req_clr_o || sys_rst_o)) begin
      idle_req = 1'b0;
      pd_req   = 1'b0;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic window(input string req, input int exp_cpu, input int exp_per);
    n_cpu = 0; n_per = 0;
    steps(20);
    check(n_cpu == exp_cpu, {req, " cpu_ce count"}, n_cpu, exp_cpu);
    check(n_per == exp_per, {req, " per_ce count"}, n_per, exp_per);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(mode_o == 2'd0, "R1 mode", int'(mode_o), 0);
    check(!sys_rst_o && !req_clr_o, "R1 rst/clr", int'(sys_rst_o), 0);
    check(osc_en_o == 1'b1, "R1 osc_en", int'(osc_en_o), 1);

    // R4 half-rate enables in run
    window("R4", 10, 10);

    // R5 idle entry, CPU stopped
    idle_req = 1'b1; step();
    check(mode_o == 2'd1, "R5 idle entry", int'(mode_o), 1);
    window("R5", 0, 10);

    // R6 interrupt wakes idle, clear strobe
    irq_pend = 1'b1; step(); irq_pend = 1'b0;
    check(mode_o == 2'd0, "R6 wake", int'(mode_o), 0);
    check(req_clr_o == 1'b1, "R10 strobe on exit", int'(req_clr_o), 1);
    steps(4);

    // R10 request still set in the cycle after an exit is ignored
    auto_clr = 0;
    idle_req = 1'b1; step();
    irq_pend = 1'b1; step(); irq_pend = 1'b0;
    step();
    check(mode_o == 2'd0, "R10 guard cycle", int'(mode_o), 0);
    step();
    check(mode_o == 2'd1, "R10 re-entry", int'(mode_o), 1);
    irq_pend = 1'b1; idle_req = 1'b0; step(); irq_pend = 1'b0;
    auto_clr = 1;
    steps(3);

    // R2 a 23-edge pulse is not a reset
    rst_pin = 1'b1; steps(23);
    check(sys_rst_o == 1'b0, "R2 short pulse", int'(sys_rst_o), 0);
    rst_pin = 1'b0; steps(2);
    // R2/R3 full pulse
    rst_pin = 1'b1; steps(23);
    check(sys_rst_o == 1'b0, "R2 edge 23", int'(sys_rst_o), 0);
    step();
    check(sys_rst_o == 1'b1, "R2 edge 24", int'(sys_rst_o), 1);
    check(mode_o == 2'd3, "R3 reset mode", int'(mode_o), 3);
    steps(5);
    rst_pin = 1'b0; step();
    check(sys_rst_o == 1'b0 && mode_o == 2'd0, "R3 release", int'(mode_o), 0);
    steps(3);

    // R7 power-down
    pd_req = 1'b1; step();
    check(mode_o == 2'd2 && osc_en_o == 1'b0, "R7 pd entry", int'(osc_en_o), 0);
    window("R7", 0, 0);
    // R8 wake sources ignored
    irq_pend = 1'b1; idle_req = 1'b1; pd_req = 1'b1; steps(5);
    irq_pend = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
    check(mode_o == 2'd2 && osc_en_o == 1'b0, "R8 pd holds", int'(mode_o), 2);
    // R8 reset restarts the oscillator then qualifies
    rst_pin = 1'b1; step();
    check(osc_en_o == 1'b1, "R8 osc restart", int'(osc_en_o), 1);
    steps(23);
    check(sys_rst_o == 1'b0, "R8 edge 24", int'(sys_rst_o), 0);
    step();
    check(sys_rst_o == 1'b1 && mode_o == 2'd3, "R8 edge 25", int'(sys_rst_o), 1);
    rst_pin = 1'b0; steps(3);

    // R9 both requests at once
    idle_req = 1'b1; pd_req = 1'b1; step();
    check(mode_o == 2'd2, "R9 pd priority", int'(mode_o), 2);
    rst_pin = 1'b1; steps(25); rst_pin = 1'b0; steps(2);

    // R11 reset during idle
    idle_req = 1'b1; step();
    rst_pin = 1'b1; steps(24);
    check(mode_o == 2'd3 && req_clr_o == 1'b1, "R11 idle reset", int'(mode_o), 3);
    rst_pin = 1'b0; steps(3);

    // seeded random traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 2) begin
        rst_pin = 1'b1;
        steps(int'($urandom_range(1, 40)));
        rst_pin = 1'b0;
      end else begin
        if (r < 8)  idle_req = 1'b1;
        if (r >= 8 && r < 11) pd_req = 1'b1;
        irq_pend = ($urandom_range(0, 9) == 0);
        step();
      end
      // a stuck power-down needs a reset to make progress
      if (m_mode == 2 && $urandom_range(0, 19) == 0) begin
        rst_pin = 1'b1; steps(26); rst_pin = 1'b0;
      end
    end
    irq_pend = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule